// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a bus-mapped watchdog timer. Software loads a 16-bit up-counter and turns the timer on with a control write. A prescaler then makes a tick at a chosen division of the clock, and each tick adds one to the count. If software does not reload the counter in time, the count wraps past 0xFFFF. The block then sets a sticky overflow flag and raises a single-cycle reset request for the system.

Every register write must carry its register's own key in the upper bits. A write without the correct key changes nothing. After any accepted write, the block shows a busy indication for a fixed number of clock cycles. A counter write takes effect at once. A control write is held and only applied when the busy window closes, so software waits for the busy bit to clear before it relies on a new enable or division setting.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset the count is 0, the timer is off, the division code is 0, the overflow and busy bits read 0, and `rst_req` is low.
- R2: A write to offset 0x0 is accepted only when data bits 31:16 equal 0x5A5A. It then loads data bits 15:0 into the count on that clock edge and clears the prescaler. Any other value in bits 31:16 leaves the count unchanged.
- R3: A write to offset 0x4 is accepted only when data bits 31:8 equal 0xA5A5A5, and only bits 7:0 are used. A wrong key changes no state and does not raise the busy bit.
- R4: Control bit 7 enables counting. While it is 0 the count holds its value, except when a keyed counter write loads a new one.
- R5: Status bit 5 (busy) reads 1 for exactly 3 cycles after any accepted write, and another accepted write restarts those 3 cycles. A held control value is applied on the edge where busy drops to 0. If several control writes arrive before then, the last one is applied.
- R6: Control bits 2:0 pick the tick period in clocks. Codes 0 to 6 give 1, 4, 16, 32, 64, 128 and 1024. Code 7 behaves like 1024.
- R7: With the timer on and a loaded value L, the count wraps to 0 after 65536-L ticks. On that wrap, status bit 4 (overflow) becomes 1 and `rst_req` is high for one cycle.
- R8: The overflow bit stays 1 until an applied control value has bit 4 equal to 0. An applied value with bit 4 equal to 1 leaves the flag as it is. If a new overflow falls on the same edge as an applying clear, the flag stays set.
- R9: A read at offset 0x0 returns the count in bits 15:0 with zeros above. A read at offset 0x4 returns enable in bit 7, busy in bit 5, overflow in bit 4 and the division code in bits 2:0, with all other bits 0. Any other offset reads 0.
- R10: If a keyed counter write falls in the same cycle as the tick that would wrap the count from 0xFFFF, the write wins. No overflow is flagged and no reset request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset of the register (write and read) |
| reg_wdata | input | 32 | Write data including key |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
Two pairs of events can meet on one clock edge, and the bench forces both. The first pair is a keyed counter reload and the tick that would wrap the count from 0xFFFF. The bench loads 0xFFFC at divide-by-1 and schedules a second reload exactly four cycles later, so the reload wins and no flag or reset request may appear. The second pair is a held overflow-clearing control value that becomes due on the same edge as a fresh wrap. The bench times a counter load and a clearing control write so that both land on one edge, and the flag must then stay set. A behavioural reference model compares the read data and `rst_req` on every clock edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam logic [15:0] CNT_KEY = 16'h5A5A;
   localparam logic [23:0] CTL_KEY = 24'hA5A5A5;
   localparam int unsigned OFS_CNT = 0;
   localparam int unsigned OFS_CTL = 4;
   localparam int unsigned BIT_EN  = 7;
   localparam int unsigned BIT_WIP = 5;
   localparam int unsigned BIT_OVF = 4;

   typedef struct packed {
      logic       en;
      logic       keep_ovf;
      logic [2:0] cks;
   } ctl_t;

   function automatic int unsigned div_of(input logic [2:0] code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 4;
         3'd2:    return 16;
         3'd3:    return 32;
         3'd4:    return 64;
         3'd5:    return 128;
         default: return 1024;
      endcase
   endfunction

endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode #(
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 16
) (
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              cnt_wr,
   output logic              ctl_wr,
   output logic [CNT_W-1:0]  cnt_val,
   output wdt_pkg::ctl_t     ctl_val
);
   localparam int KEY_W = 32 - CNT_W;

   if (CNT_W != 16) begin : g_bad_cnt_w
      $error("wdt_bus_decode: counter key split needs CNT_W of 16");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("wdt_bus_decode: ADDR_W too narrow for the control offset");
   end

   logic hit_cnt, hit_ctl;
   assign hit_cnt = (reg_addr == ADDR_W'(wdt_pkg::OFS_CNT));
   assign hit_ctl = (reg_addr == ADDR_W'(wdt_pkg::OFS_CTL));

   assign cnt_wr  = reg_wr && hit_cnt && (reg_wdata[31:CNT_W] == KEY_W'(wdt_pkg::CNT_KEY));
   assign ctl_wr  = reg_wr && hit_ctl && (reg_wdata[31:8] == wdt_pkg::CTL_KEY);
   assign cnt_val = reg_wdata[CNT_W-1:0];

   assign ctl_val.en       = reg_wdata[wdt_pkg::BIT_EN];
   assign ctl_val.keep_ovf = reg_wdata[wdt_pkg::BIT_OVF];
   assign ctl_val.cks      = reg_wdata[2:0];

   wire unused_wbits = ^{reg_wdata[6:5], reg_wdata[3]};
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
   parameter int BUSY_CYCLES = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_wr,
   input  logic          ctl_wr,
   input  wdt_pkg::ctl_t ctl_val,
   output logic          tmr_en,
   output logic [2:0]    cks,
   output logic          wip,
   output logic          clr_ovf
);
   localparam int BW = $clog2(BUSY_CYCLES + 1);

   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("wdt_ctrl: BUSY_CYCLES must be at least 1");
   end

   logic [BW-1:0]  busy_q;
   logic           stage_v;
   wdt_pkg::ctl_t  stage_q;
   logic           any_wr, commit;

   assign any_wr  = cnt_wr || ctl_wr;
   assign commit  = stage_v && (busy_q == BW'(1)) && !any_wr;
   assign wip     = (busy_q != '0);
   assign clr_ovf = commit && !stage_q.keep_ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= '0;
         stage_v <= 1'b0;
         stage_q <= '0;
         tmr_en  <= 1'b0;
         cks     <= '0;
      end else begin
         if (any_wr)
            busy_q <= BW'(BUSY_CYCLES);
         else if (busy_q != '0)
            busy_q <= busy_q - BW'(1);

         if (ctl_wr) begin
            stage_v <= 1'b1;
            stage_q <= ctl_val;
         end else if (commit) begin
            stage_v <= 1'b0;
         end

         if (commit) begin
            tmr_en <= stage_q.en;
            cks    <= stage_q.cks;
         end
      end
   end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PRE_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [2:0] cks,
   input  logic       clr,
   output logic       tick
);
   if ((2 ** PRE_W) < 1024) begin : g_bad_pre_w
      $error("wdt_prescaler: PRE_W cannot reach the largest division");
   end

   logic [PRE_W-1:0] pre_q;
   logic [7:0]       hit;

   for (genvar g = 0; g < 8; g++) begin : g_code
      localparam int unsigned LIM = wdt_pkg::div_of(3'(g)) - 1;
      assign hit[g] = (pre_q >= PRE_W'(LIM));
   end

   assign tick = en && hit[cks];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (clr || !en || tick)
         pre_q <= '0;
      else
         pre_q <= pre_q + PRE_W'(1);
   end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             clr_ovf,
   output logic [CNT_W-1:0] count_q,
   output logic             ovf_flag,
   output logic             rst_req
);
   logic wrap;
   assign wrap = tick && (&count_q) && !cnt_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         ovf_flag <= 1'b0;
         rst_req  <= 1'b0;
      end else begin
         if (cnt_wr)
            count_q <= cnt_val;
         else if (tick)
            count_q <= count_q + CNT_W'(1);

         if (wrap)
            ovf_flag <= 1'b1;
         else if (clr_ovf)
            ovf_flag <= 1'b0;

         rst_req <= wrap;
      end
   end
endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt #(
   parameter int ADDR_W      = 4,
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 10,
   parameter int BUSY_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              rst_req
);
   logic             cnt_wr, ctl_wr, tmr_en, wip, clr_ovf, tick, ovf_flag;
   logic [CNT_W-1:0] cnt_val, count_q;
   logic [2:0]       cks;
   wdt_pkg::ctl_t    ctl_val;

   wdt_bus_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .cnt_wr(cnt_wr), .ctl_wr(ctl_wr), .cnt_val(cnt_val), .ctl_val(ctl_val)
   );

   wdt_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .ctl_wr(ctl_wr),
      .ctl_val(ctl_val), .tmr_en(tmr_en), .cks(cks), .wip(wip), .clr_ovf(clr_ovf)
   );

   wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(tmr_en), .cks(cks), .clr(cnt_wr), .tick(tick)
   );

   wdt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cnt_val(cnt_val),
      .clr_ovf(clr_ovf), .count_q(count_q), .ovf_flag(ovf_flag), .rst_req(rst_req)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(wdt_pkg::OFS_CNT)) begin
         reg_rdata[CNT_W-1:0] = count_q;
      end else if (reg_addr == ADDR_W'(wdt_pkg::OFS_CTL)) begin
         reg_rdata[wdt_pkg::BIT_EN]  = tmr_en;
         reg_rdata[wdt_pkg::BIT_WIP] = wip;
         reg_rdata[wdt_pkg::BIT_OVF] = ovf_flag;
         reg_rdata[2:0]              = cks;
      end
   end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              cnt_wr,
   input logic              tmr_en,
   input logic              wip,
   input logic [CNT_W-1:0]  count_q,
   input logic              ovf_flag,
   input logic              rst_req
);
   // R7: reset request lasts a single cycle
   a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R7: a reset request always comes with the overflow flag set
   a_r7_rst_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ovf_flag);

   // R5: a keyed counter write raises busy on the next cycle
   a_r5_wip_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(0) && reg_wdata[31:16] == 16'h5A5A) |=> wip);

   // R5: the enable only changes as the busy window closes
   a_r5_commit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tmr_en) |-> (!wip && $past(wip)));

   // R4: a stopped timer holds its count unless reloaded
   a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en && !cnt_wr) |=> $stable(count_q));
endmodule

bind keyguard_wdt wdt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wdt_checker (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .cnt_wr(cnt_wr), .tmr_en(tmr_en), .wip(wip),
   .count_q(count_q), .ovf_flag(ovf_flag), .rst_req(rst_req)
);

// File: tb/test_keyguard_wdt.sv
`timescale 1ns/1ps
module test_keyguard_wdt;
   localparam int ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              rst_req;

   keyguard_wdt #(.ADDR_W(ADDR_W)) i_keyguard_wdt (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req)
   );

   always #4 clk = ~clk;

   int    checks = 0;
   int    failures = 0;
   string cur_req = "R1";
   bit    done = 1'b0;
   int    ovf_seen = 0;

   // reference model state
   int       m_cnt = 0, m_pre = 0, m_busy = 0;
   bit       m_en = 0, m_ovf = 0, m_sv = 0, m_rst = 0;
   bit [7:0] m_stage = 0;
   bit [2:0] m_cks = 0;

   function automatic int period(input bit [2:0] c);
      int t[8] = '{1, 4, 16, 32, 64, 128, 1024, 1024};
      return t[c];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_busy = 0; m_en = 0; m_ovf = 0;
         m_sv = 0; m_rst = 0; m_stage = 0; m_cks = 0;
      end else begin
         bit a_cnt, a_ctl, tk, cm, wr;
         a_cnt = reg_wr && reg_addr == 0 && reg_wdata[31:16] == 16'h5A5A;
         a_ctl = reg_wr && reg_addr == 4 && reg_wdata[31:8] == 24'hA5A5A5;
         tk = m_en && (m_pre >= period(m_cks) - 1);
         cm = m_sv && m_busy == 1 && !(a_cnt || a_ctl);
         wr = tk && m_cnt == 16'hFFFF && !a_cnt;
         m_rst = wr;
         if (wr) ovf_seen++;
         if (wr) m_ovf = 1;
         else if (cm && !m_stage[4]) m_ovf = 0;
         if (a_cnt) begin m_cnt = int'(reg_wdata[15:0]); m_pre = 0; end
         else if (tk) begin m_cnt = (m_cnt + 1) & 16'hFFFF; m_pre = 0; end
         else if (m_en) m_pre++;
         else m_pre = 0;
         if (cm) begin m_en = m_stage[7]; m_cks = m_stage[2:0]; end
         if (a_ctl) begin m_sv = 1; m_stage = reg_wdata[7:0]; end
         else if (cm) m_sv = 0;
         if (a_cnt || a_ctl) m_busy = 3;
         else if (m_busy > 0) m_busy--;
      end
      #2;
      if (!done) begin
         logic [31:0] e;
         e = 32'h0;
         if (reg_addr == 0) e[15:0] = m_cnt[15:0];
         else if (reg_addr == 4) e = {24'h0, m_en, 1'b0, m_busy != 0, m_ovf, 1'b0, m_cks};
         chk(cur_req, reg_rdata, e);
         chk(cur_req, {31'h0, rst_req}, {31'h0, m_rst});
      end
   end

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         reg_addr = (reg_addr == 0) ? 4'd4 : 4'd0;
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog timeout in %s", cur_req);
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      cur_req = "R1"; idle(3);
      rst_n = 1'b1; idle(4);

      cur_req = "R2"; wr(0, 32'h1234_0010); idle(5);
      wr(0, 32'h5A5A_1234); idle(5);
      wr(4, 32'h5A5A_0020); idle(3);

      cur_req = "R3"; wr(4, 32'hA5A5_A480); idle(6);
      wr(0, 32'hA5A5_A582); idle(6);

      cur_req = "R5"; wr(4, 32'hA5A5_A502); wr(0, 32'h5A5A_FF00);
      idle(1); wr(4, 32'hA5A5_A592); wr(4, 32'hA5A5_A591); idle(200);

      cur_req = "R4"; wr(4, 32'hA5A5_A501); idle(50);
      chk("R4", {31'h0, i_keyguard_wdt.rst_req}, 32'h0);

      cur_req = "R7"; wr(0, 32'h5A5A_FFF8); wr(4, 32'hA5A5_A580); idle(30);
      chk("R7", ovf_seen, 1);
      cur_req = "R8"; wr(4, 32'hA5A5_A590); idle(6);
      wr(4, 32'hA5A5_A580); idle(6);

      cur_req = "R10"; wr(0, 32'h5A5A_FFFC); idle(3); wr(0, 32'h5A5A_1000); idle(5);
      chk("R10", ovf_seen, 1);

      cur_req = "R8"; wr(0, 32'h5A5A_FFF0); idle(20);
      wr(0, 32'h5A5A_FFFC); wr(4, 32'hA5A5_A580); idle(10);

      cur_req = "R9"; reg_addr = 4'd8; idle(1); reg_addr = 4'd8; @(negedge clk);
      reg_addr = 4'd2; @(negedge clk); idle(2);

      cur_req = "R6";
      for (int c = 1; c < 8; c++) begin
         wr(0, 32'h5A5A_FFFD);
         wr(4, 32'hA5A5_A580 | c);
         idle(period(3'(c)) * 4 + 20);
      end
      chk("R6", ovf_seen >= 8, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule